// File: doc/BRIEF.md
# Bus-Master IDE Register Window

This block decodes the byte-wide control registers that a host sees in the bus-master I/O window of a two-channel IDE controller. Each channel owns an 8-byte slot of a 16-byte window. Within a slot, the two low address bits pick one of four registers:

| Low bits | Register |
|---|---|
| 0 | Command byte, passed on to the DMA engine |
| 1 | View of the mode/interrupt register that both channels share |
| 2 | Status byte |
| 3 | Channel's UDMA timing byte |

The upper four bytes of each slot hold the descriptor pointer. That pointer is kept elsewhere, so this block leaves those bytes alone.

Host accesses arrive on a simple port that carries address, size code, read and write strobes and 32-bit data. Read data returns one cycle after the read strobe.

The block has two sideband links. The DMA engine receives the command byte of each channel, with a strobe on every write. It sends back the active level and the error and interrupt set pulses for the status byte. The interrupt logic updates the shared mode register through a masked merge. It is told through a strobe whenever the host writes that register, so that it can evaluate its output again.

Top module: `bmide_regwin`

## Requirements
- R1: After reset, every register reads 0, `io_rvalid` is 0, both strobes are 0, and `dma_cmd`, `mode_q` and `udma_tim` are 0.
- R2: Channel c uses window bytes 8c to 8c+3, and `io_addr[1:0]` selects the register. A byte access with `io_addr[2]`=1 reads 0, and writing it changes no register.
- R3: `io_rvalid` is high exactly in the cycle after `io_rd`. `io_rdata` then holds the register value as it was in the cycle of the read.
- R4: The size code (`io_size` 0=1 byte, 1=2 bytes, 2 or 3=4 bytes) governs accesses wider than a byte. Such a read returns all ones in its low 8, 16 or 32 bits and zeros above. Such a write changes no register.
- R5: A byte write to offset 0 stores the whole byte. The byte appears on that channel's lane of `dma_cmd` in the next cycle, together with a one-cycle `dma_cmd_stb` pulse, and offset 0 reads it back.
- R6: A byte write of d to status (offset 2) gives bits 6:5 = d[6:5] and bits 2:1 = old & ~d. Bits 7, 4 and 3 become 0, and bit 0 is not written.
- R7: Status bit 0 equals the channel's `dma_active` from the previous cycle, whatever the host writes.
- R8: `dma_err_set` sets status bit 1 and `dma_irq_set` sets status bit 2. A set wins over a write-1-to-clear in the same cycle.
- R9: Offset 1 of either channel reads `mode_q`. A byte write there replaces only bits 5:4, and `mode_wr_stb` pulses in the next cycle.
- R10: When `irq_upd_we` is high, `mode_q` takes `irq_upd_val` under `irq_upd_mask` and keeps its other bits. If a host write to offset 1 falls in the same cycle, the host owns bits 5:4.
- R11: A byte write to offset 3 replaces the whole timing byte of that channel. The byte appears on the channel's lane of `udma_tim` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Byte address within the window |
| io_size | input | 2 | Access size code: 0=1 byte, 1=2 bytes, 2/3=4 bytes |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 32 | Write data; a byte access uses bits 7:0 |
| io_rdata | output | 32 | Read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read data valid, one cycle after io_rd |
| dma_cmd | output | 16 | Command byte per channel, channel c on bits 8c+7:8c |
| dma_cmd_stb | output | 2 | One-cycle pulse per channel after a command write |
| dma_active | input | 2 | DMA active level per channel |
| dma_err_set | input | 2 | Sets status error bit per channel |
| dma_irq_set | input | 2 | Sets status interrupt bit per channel |
| mode_q | output | 8 | Shared mode/interrupt register |
| mode_wr_stb | output | 1 | Pulse after a host write to the mode register |
| irq_upd_we | input | 1 | Interrupt-logic update enable |
| irq_upd_mask | input | 8 | Bits of mode_q the update replaces |
| irq_upd_val | input | 8 | New values for the masked bits |
| udma_tim | output | 16 | Timing byte per channel, channel c on bits 8c+7:8c |

## Verification
Two kinds of collision can fall into one clock cycle. The first is a host write-1-to-clear on the status byte meeting an error or interrupt set pulse from the DMA engine. The second is a host write to the mode byte meeting a masked update from the interrupt logic. The bench provokes both collisions directly and also throws sparse random set pulses and updates under a random stream of host accesses. It judges the result by reading the status and mode bytes back through the window. The expected values come from its own bit-level restatement, in which a set beats a clear and the host owns mode bits 5:4.

// File: rtl/bmw_pkg.sv
package bmw_pkg;
  localparam int DW = 32;
  localparam logic [1:0] OFF_CMD  = 2'd0;
  localparam logic [1:0] OFF_MODE = 2'd1;
  localparam logic [1:0] OFF_STAT = 2'd2;
  localparam logic [1:0] OFF_TIM  = 2'd3;
  localparam logic [7:0] MODE_HOST_BITS = 8'h30;
  localparam logic [7:0] STAT_RW_BITS   = 8'h60;
  localparam logic [7:0] STAT_CLR_BITS  = 8'h06;
  localparam logic [7:0] STAT_KEEP_BITS = 8'h01;

  // host write to status: plain bits, clear-on-one bits, preserved bit
  function automatic logic [7:0] stat_after_write(logic [7:0] old, logic [7:0] d);
    return (d & STAT_RW_BITS) | (old & STAT_KEEP_BITS) | (old & ~d & STAT_CLR_BITS);
  endfunction

  function automatic logic [7:0] masked_merge(logic [7:0] old, logic [7:0] mask,
                                              logic [7:0] val);
    return (old & ~mask) | (val & mask);
  endfunction

  function automatic logic [DW-1:0] ones_for_size(logic [1:0] sz);
    case (sz)
      2'd0:    return DW'(32'h0000_00FF);
      2'd1:    return DW'(32'h0000_FFFF);
      default: return {DW{1'b1}};
    endcase
  endfunction
endpackage

// File: rtl/bmw_decode.sv
module bmw_decode
  import bmw_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW = CW + 3
) (
  input  logic [AW-1:0]  io_addr,
  input  logic [1:0]     io_size,
  input  logic           io_wr,
  output logic           in_win,
  output logic [CW-1:0]  ch_sel,
  output logic [1:0]     reg_sel,
  output logic [NCH-1:0] cmd_we,
  output logic [NCH-1:0] stat_we,
  output logic [NCH-1:0] tim_we,
  output logic           mode_we
);
  logic wr_hit;

  assign ch_sel  = io_addr[AW-1:3];
  assign reg_sel = io_addr[1:0];
  assign in_win  = !io_addr[2] && (int'(ch_sel) < NCH);
  assign wr_hit  = io_wr && (io_size == 2'd0) && in_win;
  assign mode_we = wr_hit && (reg_sel == OFF_MODE);

  for (genvar c = 0; c < NCH; c++) begin : g_we
    logic mine;
    assign mine       = wr_hit && (ch_sel == CW'(c));
    assign cmd_we[c]  = mine && (reg_sel == OFF_CMD);
    assign stat_we[c] = mine && (reg_sel == OFF_STAT);
    assign tim_we[c]  = mine && (reg_sel == OFF_TIM);
  end
endmodule

// File: rtl/bmw_chan.sv
module bmw_chan
  import bmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] wdata,
  input  logic       cmd_we,
  input  logic       stat_we,
  input  logic       tim_we,
  input  logic       active,
  input  logic       err_set,
  input  logic       irq_set,
  output logic [7:0] cmd_q,
  output logic       cmd_stb,
  output logic [7:0] stat_q,
  output logic [7:0] tim_q
);
  logic [7:0] stat_next;

  always_comb begin
    stat_next    = stat_we ? stat_after_write(stat_q, wdata) : stat_q;
    stat_next[0] = active;
    stat_next[1] = stat_next[1] | err_set;
    stat_next[2] = stat_next[2] | irq_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      cmd_stb <= 1'b0;
      stat_q  <= '0;
      tim_q   <= '0;
    end else begin
      cmd_stb <= cmd_we;
      stat_q  <= stat_next;
      if (cmd_we) cmd_q <= wdata;
      if (tim_we) tim_q <= wdata;
    end
  end
endmodule

// File: rtl/bmw_mode.sv
module bmw_mode
  import bmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic [7:0] host_data,
  input  logic       upd_we,
  input  logic [7:0] upd_mask,
  input  logic [7:0] upd_val,
  output logic [7:0] mode_q,
  output logic       wr_stb
);
  logic [7:0] after_upd, mode_next;

  always_comb begin
    after_upd = upd_we ? masked_merge(mode_q, upd_mask, upd_val) : mode_q;
    mode_next = host_we ? masked_merge(after_upd, MODE_HOST_BITS, host_data) : after_upd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      wr_stb <= 1'b0;
    end else begin
      mode_q <= mode_next;
      wr_stb <= host_we;
    end
  end
endmodule

// File: rtl/bmide_regwin.sv
module bmide_regwin
  import bmw_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW = CW + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    io_addr,
  input  logic [1:0]       io_size,
  input  logic             io_rd,
  input  logic             io_wr,
  input  logic [DW-1:0]    io_wdata,
  output logic [DW-1:0]    io_rdata,
  output logic             io_rvalid,
  output logic [NCH*8-1:0] dma_cmd,
  output logic [NCH-1:0]   dma_cmd_stb,
  input  logic [NCH-1:0]   dma_active,
  input  logic [NCH-1:0]   dma_err_set,
  input  logic [NCH-1:0]   dma_irq_set,
  output logic [7:0]       mode_q,
  output logic             mode_wr_stb,
  input  logic             irq_upd_we,
  input  logic [7:0]       irq_upd_mask,
  input  logic [7:0]       irq_upd_val,
  output logic [NCH*8-1:0] udma_tim
);
  logic           in_win;
  logic [CW-1:0]  ch_sel;
  logic [1:0]     reg_sel;
  logic [NCH-1:0] cmd_we, stat_we, tim_we;
  logic           mode_we;
  logic [7:0]     cmd_arr  [NCH];
  logic [7:0]     stat_arr [NCH];
  logic [7:0]     tim_arr  [NCH];
  logic [NCH*8-1:0] stat_flat;
  logic [7:0]     rd_byte;
  logic [DW-1:0]  rd_word;

  bmw_decode #(.NCH(NCH)) u_dec (
    .io_addr(io_addr), .io_size(io_size), .io_wr(io_wr),
    .in_win(in_win), .ch_sel(ch_sel), .reg_sel(reg_sel),
    .cmd_we(cmd_we), .stat_we(stat_we), .tim_we(tim_we), .mode_we(mode_we)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    bmw_chan u_chan (
      .clk(clk), .rst_n(rst_n), .wdata(io_wdata[7:0]),
      .cmd_we(cmd_we[c]), .stat_we(stat_we[c]), .tim_we(tim_we[c]),
      .active(dma_active[c]), .err_set(dma_err_set[c]), .irq_set(dma_irq_set[c]),
      .cmd_q(cmd_arr[c]), .cmd_stb(dma_cmd_stb[c]),
      .stat_q(stat_arr[c]), .tim_q(tim_arr[c])
    );
    assign dma_cmd[c*8 +: 8]   = cmd_arr[c];
    assign udma_tim[c*8 +: 8]  = tim_arr[c];
    assign stat_flat[c*8 +: 8] = stat_arr[c];
  end

  bmw_mode u_mode (
    .clk(clk), .rst_n(rst_n),
    .host_we(mode_we), .host_data(io_wdata[7:0]),
    .upd_we(irq_upd_we), .upd_mask(irq_upd_mask), .upd_val(irq_upd_val),
    .mode_q(mode_q), .wr_stb(mode_wr_stb)
  );

  always_comb begin
    rd_byte = '0;
    if (in_win) begin
      case (reg_sel)
        OFF_CMD:  rd_byte = cmd_arr[ch_sel];
        OFF_MODE: rd_byte = mode_q;
        OFF_STAT: rd_byte = stat_arr[ch_sel];
        default:  rd_byte = tim_arr[ch_sel];
      endcase
    end
    rd_word = (io_size != 2'd0) ? ones_for_size(io_size) : {{(DW-8){1'b0}}, rd_byte};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= io_rd;
      if (io_rd) io_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/bmw_sva.sv
module bmw_sva
  import bmw_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_rd,
  input logic             io_wr,
  input logic [1:0]       io_size,
  input logic [DW-1:0]    io_rdata,
  input logic             io_rvalid,
  input logic [NCH-1:0]   dma_active,
  input logic [NCH-1:0]   dma_err_set,
  input logic [NCH-1:0]   dma_irq_set,
  input logic [NCH*8-1:0] stat_flat,
  input logic [NCH-1:0]   cmd_we,
  input logic [NCH-1:0]   dma_cmd_stb,
  input logic             mode_we,
  input logic             mode_wr_stb,
  input logic [7:0]       mode_q,
  input logic             irq_upd_we
);
  assert_rvalid_follows_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |=> io_rvalid);
  assert_no_spurious_rvalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> !io_rvalid);
  assert_wide_read_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_size != 2'd0) |=> io_rdata == ones_for_size($past(io_size)));
  assert_wide_write_no_mode_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_size != 2'd0 && !irq_upd_we) |=> $stable(mode_q));
  assert_mode_host_bits_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && !irq_upd_we) |=> (mode_q[7:6] == $past(mode_q[7:6])) &&
                                 (mode_q[3:0] == $past(mode_q[3:0])));
  assert_mode_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> mode_wr_stb);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assert_cmd_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we[c] |=> dma_cmd_stb[c]);
    assert_cmd_strobe_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dma_cmd_stb[c] |-> $past(cmd_we[c]));
    assert_active_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dma_active[c] |=> stat_flat[c*8]);
    assert_active_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_active[c] |=> !stat_flat[c*8]);
    assert_err_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_err_set[c] |=> stat_flat[c*8+1]);
    assert_irq_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_irq_set[c] |=> stat_flat[c*8+2]);
  end
endmodule

bind bmide_regwin bmw_sva #(.NCH(NCH)) u_sva (
  .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr), .io_size(io_size),
  .io_rdata(io_rdata), .io_rvalid(io_rvalid), .dma_active(dma_active),
  .dma_err_set(dma_err_set), .dma_irq_set(dma_irq_set), .stat_flat(stat_flat),
  .cmd_we(cmd_we), .dma_cmd_stb(dma_cmd_stb), .mode_we(mode_we),
  .mode_wr_stb(mode_wr_stb), .mode_q(mode_q), .irq_upd_we(irq_upd_we)
);

// File: tb/bmide_regwin_bench.sv
module bmide_regwin_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  io_addr = '0;
  logic [1:0]  io_size = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [31:0] io_wdata = '0, io_rdata;
  logic        io_rvalid;
  logic [15:0] dma_cmd, udma_tim;
  logic [1:0]  dma_cmd_stb;
  logic [1:0]  dma_active = '0, dma_err_set = '0, dma_irq_set = '0;
  logic [7:0]  mode_q;
  logic        mode_wr_stb;
  logic        irq_upd_we = 1'b0;
  logic [7:0]  irq_upd_mask = '0, irq_upd_val = '0;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] b_cmd [2];
  logic [7:0] b_stat [2];
  logic [7:0] b_tim [2];
  logic [7:0] b_mode;

  always #5 clk = ~clk;

  bmide_regwin u_bmide_regwin (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_size(io_size),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rvalid(io_rvalid), .dma_cmd(dma_cmd), .dma_cmd_stb(dma_cmd_stb),
    .dma_active(dma_active), .dma_err_set(dma_err_set), .dma_irq_set(dma_irq_set),
    .mode_q(mode_q), .mode_wr_stb(mode_wr_stb), .irq_upd_we(irq_upd_we),
    .irq_upd_mask(irq_upd_mask), .irq_upd_val(irq_upd_val), .udma_tim(udma_tim)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] b_wide(logic [1:0] sz);
    if (sz == 2'd1) return 32'h0000FFFF;
    return 32'hFFFFFFFF;
  endfunction

  function automatic logic [7:0] b_stat_wr(logic [7:0] o, logic [7:0] d);
    return {1'b0, d[6], d[5], 2'b00, o[2] & ~d[2], o[1] & ~d[1], o[0]};
  endfunction

  // one clock of stimulus, called at a negative edge; checks after the next edge
  task automatic step(bit rd, bit wr, logic [3:0] a, logic [1:0] sz, logic [7:0] wd,
                      logic [1:0] act, logic [1:0] es, logic [1:0] is,
                      bit uwe, logic [7:0] um, logic [7:0] uv, string tag);
    logic [31:0] e_rd;
    string rtag, mtag;
    logic [1:0] e_cstb;
    bit e_mstb, bwr;
    int ch;
    ch = a[3];
    io_rd = rd; io_wr = wr; io_addr = a; io_size = sz; io_wdata = {24'hA5A5A5, wd};
    dma_active = act; dma_err_set = es; dma_irq_set = is;
    irq_upd_we = uwe; irq_upd_mask = um; irq_upd_val = uv;
    e_rd = 32'h0;
    rtag = "R2";
    if (sz != 2'd0) begin
      e_rd = b_wide(sz); rtag = "R4";
    end else if (!a[2]) begin
      case (a[1:0])
        2'd0: begin e_rd = {24'h0, b_cmd[ch]};  rtag = "R5";  end
        2'd1: begin e_rd = {24'h0, b_mode};     rtag = "R9";  end
        2'd2: begin e_rd = {24'h0, b_stat[ch]}; rtag = "R6";  end
        default: begin e_rd = {24'h0, b_tim[ch]}; rtag = "R11"; end
      endcase
    end
    if (tag != "") rtag = tag;
    bwr = wr && sz == 2'd0 && !a[2];
    e_cstb = 2'b00;
    e_mstb = bwr && a[1:0] == 2'd1;
    if (uwe) b_mode = (b_mode & ~um) | (uv & um);
    if (e_mstb) b_mode[5:4] = wd[5:4];
    for (int c = 0; c < 2; c++) begin
      if (bwr && ch == c) begin
        if (a[1:0] == 2'd0) begin b_cmd[c] = wd; e_cstb[c] = 1'b1; end
        if (a[1:0] == 2'd2) b_stat[c] = b_stat_wr(b_stat[c], wd);
        if (a[1:0] == 2'd3) b_tim[c] = wd;
      end
      b_stat[c][0] = act[c];
      b_stat[c][1] = b_stat[c][1] | es[c];
      b_stat[c][2] = b_stat[c][2] | is[c];
    end
    mtag = uwe ? "R10" : "R9";
    @(posedge clk);
    @(negedge clk);
    chk(io_rvalid == rd, "R3 rvalid", 32'(io_rvalid), 32'(rd));
    if (rd) chk(io_rdata == e_rd, rtag, io_rdata, e_rd);
    chk(dma_cmd == {b_cmd[1], b_cmd[0]}, "R5 dma_cmd", 32'(dma_cmd), {16'h0, b_cmd[1], b_cmd[0]});
    chk(dma_cmd_stb == e_cstb, "R5 strobe", 32'(dma_cmd_stb), 32'(e_cstb));
    chk(mode_q == b_mode, mtag, 32'(mode_q), 32'(b_mode));
    chk(mode_wr_stb == e_mstb, "R9 mode strobe", 32'(mode_wr_stb), 32'(e_mstb));
    chk(udma_tim == {b_tim[1], b_tim[0]}, "R11 timing", 32'(udma_tim), {16'h0, b_tim[1], b_tim[0]});
  endtask

  task automatic wr_b(logic [3:0] a, logic [7:0] d);
    step(0, 1, a, 2'd0, d, dma_active, 2'b00, 2'b00, 0, 8'h0, 8'h0, "");
  endtask

  task automatic rd_b(logic [3:0] a, string tag);
    step(1, 0, a, 2'd0, 8'h0, dma_active, 2'b00, 2'b00, 0, 8'h0, 8'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int c = 0; c < 2; c++) begin b_cmd[c] = 0; b_stat[c] = 0; b_tim[c] = 0; end
    b_mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state at the ports
    chk(io_rvalid == 1'b0, "R1 rvalid", 32'(io_rvalid), 0);
    chk(dma_cmd == 16'h0 && udma_tim == 16'h0, "R1 cmd/tim", {dma_cmd, udma_tim}, 0);
    chk(mode_q == 8'h0 && dma_cmd_stb == 2'b00 && !mode_wr_stb, "R1 mode/strobes",
        {mode_q, 6'h0, dma_cmd_stb, 7'h0, mode_wr_stb}, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 16; a++) rd_b(4'(a), "R1");

    // R5, R11 on both channels; channel 1 sits at offset 8
    wr_b(4'h0, 8'h09); wr_b(4'h8, 8'h01);
    wr_b(4'h3, 8'hA5); wr_b(4'hB, 8'h3C);
    rd_b(4'h0, "R5"); rd_b(4'h8, "R5"); rd_b(4'h3, "R11"); rd_b(4'hB, "R11");

    // R8 sets, then R6 write mix
    step(0, 0, 4'h0, 2'd0, 8'h0, 2'b00, 2'b01, 2'b01, 0, 8'h0, 8'h0, "");
    rd_b(4'h2, "R8");
    wr_b(4'h2, 8'h66); rd_b(4'h2, "R6");
    // R8 collision: irq bit set earlier, then clear bits 1 and 2 while err sets
    step(0, 0, 4'h0, 2'd0, 8'h0, 2'b00, 2'b00, 2'b01, 0, 8'h0, 8'h0, "");
    step(0, 1, 4'h2, 2'd0, 8'h06, 2'b00, 2'b01, 2'b00, 0, 8'h0, 8'h0, "");
    rd_b(4'h2, "R8");
    step(0, 1, 4'hA, 2'd0, 8'h06, 2'b00, 2'b10, 2'b10, 0, 8'h0, 8'h0, "");
    rd_b(4'hA, "R8");

    // R7 active level and host write attempt on bit 0
    dma_active = 2'b10;
    step(0, 0, 4'h0, 2'd0, 8'h0, 2'b10, 2'b00, 2'b00, 0, 8'h0, 8'h0, "");
    rd_b(4'hA, "R7");
    wr_b(4'hA, 8'h00); rd_b(4'hA, "R7");
    step(0, 1, 4'hA, 2'd0, 8'hFF, 2'b00, 2'b00, 2'b00, 0, 8'h0, 8'h0, "");
    rd_b(4'hA, "R7");

    // R9 / R10 shared mode register
    wr_b(4'h1, 8'hFF); rd_b(4'h9, "R9");
    step(0, 0, 4'h0, 2'd0, 8'h0, 2'b00, 2'b00, 2'b00, 1, 8'h0C, 8'h04, "");
    rd_b(4'h1, "R10");
    step(0, 1, 4'h9, 2'd0, 8'h10, 2'b00, 2'b00, 2'b00, 1, 8'h3C, 8'h08, "");
    rd_b(4'h1, "R10");

    // R4 wide accesses
    step(1, 0, 4'h3, 2'd1, 8'h0, 2'b00, 2'b00, 2'b00, 0, 8'h0, 8'h0, "R4");
    step(1, 0, 4'h0, 2'd2, 8'h0, 2'b00, 2'b00, 2'b00, 0, 8'h0, 8'h0, "R4");
    step(1, 0, 4'h9, 2'd3, 8'h0, 2'b00, 2'b00, 2'b00, 0, 8'h0, 8'h0, "R4");
    step(0, 1, 4'h3, 2'd1, 8'h77, 2'b00, 2'b00, 2'b00, 0, 8'h0, 8'h0, "");
    step(0, 1, 4'h1, 2'd2, 8'hFF, 2'b00, 2'b00, 2'b00, 0, 8'h0, 8'h0, "");
    rd_b(4'h3, "R4"); rd_b(4'h1, "R4");

    // R2 unused bytes of each slot
    wr_b(4'h4, 8'hFF); wr_b(4'hD, 8'hFF); wr_b(4'h7, 8'hFF);
    rd_b(4'h4, "R2"); rd_b(4'hE, "R2");
    for (int a = 0; a < 16; a++) if (a[2] == 0) rd_b(4'(a), "R2");

    // constrained random traffic
    seed = $urandom(32'h5EED1234);
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] sz;
      bit r, w;
      sz = ($urandom % 8 == 0) ? 2'($urandom % 4) : 2'd0;
      r = ($urandom % 2) == 1;
      w = !r && ($urandom % 3) != 0;
      step(r, w, 4'($urandom % 16), sz, 8'($urandom),
           2'($urandom), (($urandom % 6) == 0) ? 2'($urandom) : 2'b00,
           (($urandom % 6) == 0) ? 2'($urandom) : 2'b00,
           ($urandom % 5) == 0, 8'($urandom), 8'($urandom), "");
    end
    io_rd = 0; io_wr = 0;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule